// File: doc/BRIEF.md
# Exception Readiness Checker

This block answers one question for an interrupt controller: could a named exception pre-empt the code that is running right now? A query carries an exception number and a bank selector. The block looks up that vector's enable bit and grouped priority in the secure or the non-secure table, then compares the priority against the signed running execution priority. It returns a single ready bit. Grouping raw priority fields into group priorities is done elsewhere, so the grouped values arrive here as inputs.

The hard-fault vector is a special case. Its readiness depends only on whether the running priority is above -1. Its enable bit and its configured priority are never looked at. Queries that name an exception number the block does not accept come back with ready low and an error flag set.

Queries enter on a valid/ready handshake and results leave on another, with one register stage between them. A query is accepted on a clock edge where `qry_valid` and `qry_ready` are both high. The tables and the running priority are sampled on that same edge. The result appears on the next cycle. A result that the consumer has not taken stays on the outputs without change. While it waits, `qry_ready` stays low, so back-pressure passes straight through to the query side.

Top module: `exrdy_checker`

## Requirements
- R1: After reset, `rsp_valid` is low and `qry_ready` is high.
- R2: For exception number 3 (hard fault), the result is ready exactly when the running priority is strictly greater than -1. This holds whatever the enable bits, the stored priorities or the bank selector are.
- R3: For any other legal exception, the result is ready exactly when the selected enable bit is 1 and the selected grouped priority is strictly less than the running priority.
- R4: The secure table entry is used only when the exception is banked and `qry_sec` is 1. In every other case the non-secure entry is used. With the default parameters, the banked exception numbers are 3, 4, 6, 11, 14 and 15.
- R5: A query is illegal when its exception number is 0, 1, or not below NUM_EXC, or when `qry_sec` is 1 for a non-banked exception. An illegal query returns ready 0 and error 1.
- R6: A legal query returns error 0.
- R7: A query accepted on an edge produces `rsp_valid` high on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold and `qry_ready` is low. Otherwise `qry_ready` is high.
- R8: The running priority and all grouped priorities are 9-bit two's-complement values and are compared as signed numbers. Priority field i of a table occupies bits [i*9 +: 9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qry_valid | input | 1 | Query offered |
| qry_ready | output | 1 | Query can be accepted |
| qry_exc | input | EXC_W | Exception number queried |
| qry_sec | input | 1 | Bank selector, 1 = secure copy |
| vec_en_ns | input | NUM_EXC | Non-secure enable bit per exception |
| vec_en_s | input | NUM_EXC | Secure enable bit per exception |
| vec_prio_ns | input | NUM_EXC*PRIO_W | Non-secure grouped priorities, signed |
| vec_prio_s | input | NUM_EXC*PRIO_W | Secure grouped priorities, signed |
| run_prio | input | PRIO_W | Current execution priority, signed |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Exception is ready to pre-empt |
| rsp_err | output | 1 | Query was illegal |

## Verification
The bench sweeps every 5-bit exception number in both banks, with enable on and off, against several signed priority and running-priority values. The values include -1, 0 and equal priorities, which is where a design using unsigned or non-strict comparison gives the wrong answer. For each query, the opposite bank is loaded with the inverted enable bit and an extreme priority. A bank mix-up therefore shows up as a flipped result. Hard-fault queries are run with the vector disabled and with very negative priorities. A design that consults the enable bit, or compares against the stored priority, reports wrong readiness there. A stalled response is held while new inputs change, which catches a design that drops back-pressure or lets the response drift.

// File: rtl/exrdy_pkg.sv
package exrdy_pkg;
  localparam int RESET_EXC = 1;
  localparam int HF_EXC    = 3;

  typedef struct packed {
    logic hit;
    logic err;
  } exrdy_rsp_t;
endpackage

// File: rtl/exrdy_select.sv
module exrdy_select #(
  parameter int NUM_EXC = 16,
  parameter int PRIO_W  = 9,
  parameter int IDX_W   = 4
) (
  input  logic [IDX_W-1:0]          idx,
  input  logic                      use_sec,
  input  logic [NUM_EXC-1:0]        en_ns,
  input  logic [NUM_EXC-1:0]        en_s,
  input  logic [NUM_EXC*PRIO_W-1:0] prio_ns,
  input  logic [NUM_EXC*PRIO_W-1:0] prio_s,
  output logic                      sel_en,
  output logic signed [PRIO_W-1:0]  sel_prio
);
  logic signed [PRIO_W-1:0] tab_ns [NUM_EXC];
  logic signed [PRIO_W-1:0] tab_s  [NUM_EXC];

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_unpack
    assign tab_ns[i] = prio_ns[i*PRIO_W +: PRIO_W];
    assign tab_s[i]  = prio_s[i*PRIO_W +: PRIO_W];
  end

  always_comb begin
    if (use_sec) begin
      sel_en   = en_s[idx];
      sel_prio = tab_s[idx];
    end else begin
      sel_en   = en_ns[idx];
      sel_prio = tab_ns[idx];
    end
  end
endmodule

// File: rtl/exrdy_decide.sv
module exrdy_decide
  import exrdy_pkg::*;
#(
  parameter int               NUM_EXC     = 16,
  parameter int               EXC_W       = 5,
  parameter int               PRIO_W      = 9,
  parameter int               IDX_W       = 4,
  parameter logic [NUM_EXC-1:0] BANKED_MASK = 16'hC858
) (
  input  logic [EXC_W-1:0]         exc,
  input  logic                     sec,
  input  logic                     sel_en,
  input  logic signed [PRIO_W-1:0] sel_prio,
  input  logic signed [PRIO_W-1:0] run_prio,
  output logic [IDX_W-1:0]         idx,
  output logic                     use_sec,
  output exrdy_rsp_t               rsp
);
  localparam logic signed [PRIO_W-1:0] NEG_ONE = '1;

  logic in_range, banked, legal, is_hf;

  always_comb begin
    in_range = (int'(exc) < NUM_EXC);
    idx      = in_range ? exc[IDX_W-1:0] : '0;
    banked   = in_range && BANKED_MASK[idx];
    legal    = in_range && (int'(exc) > RESET_EXC) && (!sec || banked);
    is_hf    = (int'(exc) == HF_EXC);
    use_sec  = banked && sec;
    rsp.err  = !legal;
    if (!legal)
      rsp.hit = 1'b0;
    else if (is_hf)
      rsp.hit = (run_prio > NEG_ONE);
    else
      rsp.hit = sel_en && (sel_prio < run_prio);
  end

  always_comb begin
    assert_illegal_quiet_R5: assert (!(rsp.err && rsp.hit));
  end
endmodule

// File: rtl/exrdy_checker.sv
module exrdy_checker
  import exrdy_pkg::*;
#(
  parameter int                 NUM_EXC     = 16,
  parameter int                 EXC_W       = 5,
  parameter int                 PRIO_W      = 9,
  parameter logic [NUM_EXC-1:0] BANKED_MASK = 16'hC858
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        qry_valid,
  output logic                        qry_ready,
  input  logic [EXC_W-1:0]            qry_exc,
  input  logic                        qry_sec,
  input  logic [NUM_EXC-1:0]          vec_en_ns,
  input  logic [NUM_EXC-1:0]          vec_en_s,
  input  logic [NUM_EXC*PRIO_W-1:0]   vec_prio_ns,
  input  logic [NUM_EXC*PRIO_W-1:0]   vec_prio_s,
  input  logic signed [PRIO_W-1:0]    run_prio,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_hit,
  output logic                        rsp_err
);
  localparam int IDX_W = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1;
  localparam logic signed [PRIO_W-1:0] NEG_ONE = '1;

  logic [IDX_W-1:0]         idx;
  logic                     use_sec, sel_en, fire;
  logic signed [PRIO_W-1:0] sel_prio;
  exrdy_rsp_t               nxt, held;

  exrdy_select #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_select (
    .idx(idx), .use_sec(use_sec), .en_ns(vec_en_ns), .en_s(vec_en_s),
    .prio_ns(vec_prio_ns), .prio_s(vec_prio_s),
    .sel_en(sel_en), .sel_prio(sel_prio)
  );

  exrdy_decide #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .PRIO_W(PRIO_W),
                 .IDX_W(IDX_W), .BANKED_MASK(BANKED_MASK)) u_decide (
    .exc(qry_exc), .sec(qry_sec), .sel_en(sel_en), .sel_prio(sel_prio),
    .run_prio(run_prio), .idx(idx), .use_sec(use_sec), .rsp(nxt)
  );

  assign qry_ready = !rsp_valid || rsp_ready;
  assign fire      = qry_valid && qry_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      held      <= '0;
    end else begin
      if (fire) begin
        rsp_valid <= 1'b1;
        held      <= nxt;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign rsp_hit = held.hit;
  assign rsp_err = held.err;

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_err)));
  assert_hardfault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && int'(qry_exc) == HF_EXC) |=> (rsp_hit == ($past(run_prio) > NEG_ONE)));
  assert_low_exc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && int'(qry_exc) <= RESET_EXC) |=> (rsp_err && !rsp_hit));
endmodule

// File: tb/exrdy_checker_bench.sv
module exrdy_checker_bench;
  localparam int NUM_EXC = 16;
  localparam int EXC_W   = 5;
  localparam int PW      = 9;
  localparam logic [NUM_EXC-1:0] BANKED = 16'hC858;

  logic clk = 1'b0, rst_n = 1'b0;
  logic qry_valid = 1'b0, qry_sec = 1'b0, rsp_ready = 1'b1;
  logic [EXC_W-1:0] qry_exc = '0;
  logic [NUM_EXC-1:0] en_ns = '0, en_s = '0;
  logic [NUM_EXC*PW-1:0] pr_ns = '0, pr_s = '0;
  logic signed [PW-1:0] run_prio = '0;
  logic qry_ready, rsp_valid, rsp_hit, rsp_err;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exrdy_checker #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .PRIO_W(PW), .BANKED_MASK(BANKED))
  u_exrdy_checker (
    .clk(clk), .rst_n(rst_n), .qry_valid(qry_valid), .qry_ready(qry_ready),
    .qry_exc(qry_exc), .qry_sec(qry_sec), .vec_en_ns(en_ns), .vec_en_s(en_s),
    .vec_prio_ns(pr_ns), .vec_prio_s(pr_s), .run_prio(run_prio),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_err(rsp_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d exc=%0d sec=%0d", req, act, exp, qry_exc, qry_sec);
    end
  endtask

  initial begin
    int pv[5] = '{-3, -1, 0, 5, 255};
    int rv[7] = '{-2, -1, 0, 4, 5, 6, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 qry_ready", qry_ready, 1);

    for (int e = 0; e < 32; e++)
      for (int s = 0; s < 2; s++)
        for (int en = 0; en < 2; en++)
          for (int pi = 0; pi < 5; pi++)
            for (int ri = 0; ri < 7; ri++) begin
              bit legal, banked, hit, usesec;
              int otherp;
              banked = (e < NUM_EXC) && BANKED[e % NUM_EXC];
              legal  = (e > 1) && (e < NUM_EXC) && (s == 0 || banked);
              usesec = banked && (s == 1);
              otherp = (pv[pi] < 0) ? 255 : -256;
              en_ns = en ? '0 : '1;
              en_s  = en ? '0 : '1;
              for (int k = 0; k < NUM_EXC; k++) begin
                pr_ns[k*PW +: PW] = PW'(otherp);
                pr_s[k*PW +: PW]  = PW'(otherp);
              end
              if (e < NUM_EXC) begin
                if (usesec) begin
                  en_s[e] = en[0];
                  pr_s[e*PW +: PW] = PW'(pv[pi]);
                end else begin
                  en_ns[e] = en[0];
                  pr_ns[e*PW +: PW] = PW'(pv[pi]);
                end
              end
              run_prio = PW'(rv[ri]);
              qry_exc = EXC_W'(e);
              qry_sec = s[0];
              if (!legal) hit = 0;
              else if (e == 3) hit = rv[ri] > -1;
              else hit = (en == 1) && (pv[pi] < rv[ri]);
              qry_valid = 1'b1;
              @(negedge clk);
              qry_valid = 1'b0;
              check("R7 valid", rsp_valid, 1);
              if (e == 3 && legal) check("R2 hardfault", rsp_hit, hit);
              else if (!legal) check("R5 illegal hit", rsp_hit, 0);
              else if (usesec) check("R4 secure bank", rsp_hit, hit);
              else check("R3 R8 compare", rsp_hit, hit);
              if (legal) check("R6 err", rsp_err, 0);
              else check("R5 err", rsp_err, 1);
            end

    // back-pressure: hold response while inputs change
    @(negedge clk);
    en_ns = '1; en_s = '1;
    qry_exc = 5'd3; qry_sec = 1'b0; run_prio = 9'sd0; qry_valid = 1'b1; rsp_ready = 1'b0;
    @(negedge clk);
    check("R7 held valid", rsp_valid, 1);
    check("R7 qry_ready low", qry_ready, 0);
    check("R2 hf ready", rsp_hit, 1);
    qry_exc = 5'd0; run_prio = -9'sd2;
    @(negedge clk);
    check("R7 hold hit", rsp_hit, 1);
    check("R7 hold err", rsp_err, 0);
    check("R7 hold valid", rsp_valid, 1);
    qry_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    check("R7 drain", rsp_valid, 0);
    check("R7 ready again", qry_ready, 1);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule